// File: doc/BRIEF.md
# Event Interrupt Register Bank

This block gathers completion events from a set of channel sequencers and presents them to software as sticky pending bits behind a small register map. Each sequencer raises an event with a one-cycle pulse that carries a 5-bit event number. The bank latches that event in a raw pending register. An enable register masks the pending bits. The masked result drives one interrupt line per event and one combined interrupt line.

Software claims a channel by setting that channel's enable bit. When an interrupt arrives, software reads the masked status and acknowledges each event by writing a one to its bit in the clear register. Events and clears may land in the same cycle; in that case the event wins. A read-only configuration word reports how many events are implemented, so that one driver can serve every build of the block.

The register port is plain: a request strobe, a write flag, a byte address and 32-bit write data. Read data is registered and returned on the cycle after the read request.

Top module: `evt_irq_bank`

## Requirements
- R1: After reset the enable and raw pending registers are zero, `irq_o` and `evt_irq_o` are low, and `rdata_o` is zero.
- R2: The enable register at byte offset 0x020 is readable and writable. Bits at or above NUM_EVENTS read as zero.
- R3: An event pulse on any channel with index k below NUM_EVENTS sets bit k of the raw pending register at offset 0x024 on the next clock edge. Pulses on several channels in the same cycle all take effect.
- R4: A raw pending bit stays set until it is cleared. A repeated event for a bit that is already pending changes nothing.
- R5: Writing to offset 0x02C clears every raw pending bit whose write-data bit is one. Zero bits have no effect. A read of 0x02C returns zero.
- R6: If an event and a clear hit the same bit in the same cycle, the bit is set after that edge.
- R7: The masked status at offset 0x028 equals raw AND enable. `evt_irq_o[n]` is masked bit n, and `irq_o` is high exactly when any masked bit is set.
- R8: An event pulse whose index is NUM_EVENTS or above has no effect.
- R9: The configuration word at offset 0xE00 holds NUM_EVENTS-1 in bits [21:17] and zero in all other bits. Writes to it are ignored.
- R10: Reads of any other offset, including unaligned ones, return zero. Writes to those offsets, and to 0x024 and 0x028, change no state.
- R11: Read data appears on `rdata_o` one cycle after a read request and holds until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| evt_vld_i | input | NUM_CHAN | Per-channel event pulse |
| evt_idx_i | input | NUM_CHAN*5 | Per-channel event index, channel c in bits [5c+4:5c] |
| irq_o | output | 1 | Combined interrupt |
| evt_irq_o | output | NUM_EVENTS | Per-event masked interrupt lines |

## Verification
Directed sequences apply single events, events on all channels at once, out-of-range indices, repeated events on pending bits and clears that collide with events. These separate correct latching from lost or spurious bits, and they pin down the event-over-clear priority. Enable patterns that cover none, some and all of the pending bits separate masking faults from latching faults on both the status read and the interrupt lines. A long random phase mixes accesses to every offset, including unused and read-only ones, with random event traffic, and a behavioural model checks the outputs on every clock.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int unsigned IDX_W      = 5;
  localparam int unsigned MAX_EVENTS = 1 << IDX_W;
  localparam int unsigned OFF_EN     = 32'h020;
  localparam int unsigned OFF_RAW    = 32'h024;
  localparam int unsigned OFF_MSK    = 32'h028;
  localparam int unsigned OFF_CLR    = 32'h02C;
  localparam int unsigned OFF_CFG    = 32'hE00;
  localparam int unsigned CFG_LSB    = 17;
endpackage

// File: rtl/eirq_evt_decode.sv
module eirq_evt_decode
  import eirq_pkg::*;
#(
  parameter int unsigned NUM_CHAN   = 4,
  parameter int unsigned NUM_EVENTS = 16
) (
  input  logic [NUM_CHAN-1:0]       evt_vld_i,
  input  logic [NUM_CHAN*IDX_W-1:0] evt_idx_i,
  output logic [NUM_EVENTS-1:0]     set_mask_o
);
  logic [NUM_EVENTS-1:0] hit [NUM_CHAN];

  // out-of-range indices match no bit
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    for (genvar e = 0; e < NUM_EVENTS; e++) begin : g_evt
      assign hit[c][e] = evt_vld_i[c] && (evt_idx_i[c*IDX_W +: IDX_W] == IDX_W'(e));
    end
  end

  always_comb begin
    set_mask_o = '0;
    for (int c = 0; c < NUM_CHAN; c++) set_mask_o = set_mask_o | hit[c];
  end
endmodule

// File: rtl/eirq_status.sv
module eirq_status #(
  parameter int unsigned NUM_EVENTS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_EVENTS-1:0] set_mask_i,
  input  logic [NUM_EVENTS-1:0] clr_mask_i,
  output logic [NUM_EVENTS-1:0] raw_o
);
  logic [NUM_EVENTS-1:0] raw_q;

  // set applied after clear: event wins a collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= (raw_q & ~clr_mask_i) | set_mask_i;
  end

  assign raw_o = raw_q;

  assert_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_mask_i != '0) |=> ((raw_q & $past(set_mask_i)) == $past(set_mask_i)));

  assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_q & ~clr_mask_i) != '0) |=> ((raw_q & $past(raw_q & ~clr_mask_i)) == $past(raw_q & ~clr_mask_i)));

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_mask_i & ~set_mask_i) != '0) |=> ((raw_q & $past(clr_mask_i & ~set_mask_i)) == '0));

  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_mask_i & set_mask_i) != '0) |=> ((raw_q & $past(clr_mask_i & set_mask_i)) == $past(clr_mask_i & set_mask_i)));

  assert_no_spurious_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((raw_q & ~$past(raw_q) & ~$past(set_mask_i)) == '0));
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int unsigned AW         = 12,
  parameter int unsigned DW         = 32,
  parameter int unsigned NUM_EVENTS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic [NUM_EVENTS-1:0] raw_i,
  output logic [DW-1:0]         rdata_o,
  output logic [NUM_EVENTS-1:0] en_o,
  output logic [NUM_EVENTS-1:0] clr_mask_o
);
  localparam logic [AW-1:0] A_EN  = AW'(OFF_EN);
  localparam logic [AW-1:0] A_RAW = AW'(OFF_RAW);
  localparam logic [AW-1:0] A_MSK = AW'(OFF_MSK);
  localparam logic [AW-1:0] A_CLR = AW'(OFF_CLR);
  localparam logic [AW-1:0] A_CFG = AW'(OFF_CFG);
  localparam logic [DW-1:0] CFG_VAL = DW'((NUM_EVENTS - 1) << CFG_LSB);

  logic [NUM_EVENTS-1:0] en_q;
  logic [DW-1:0]         rdata_q;
  logic [DW-1:0]         rd_val;
  logic                  wr, rd;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   en_q <= '0;
    else if (wr && addr_i == A_EN) en_q <= wdata_i[NUM_EVENTS-1:0];
  end

  assign clr_mask_o = (wr && addr_i == A_CLR) ? wdata_i[NUM_EVENTS-1:0] : '0;

  always_comb begin
    case (addr_i)
      A_EN:    rd_val = DW'(en_q);
      A_RAW:   rd_val = DW'(raw_i);
      A_MSK:   rd_val = DW'(raw_i & en_q);
      A_CFG:   rd_val = CFG_VAL;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
  assign en_o    = en_q;

  assert_en_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_EN) |=> (en_q == $past(wdata_i[NUM_EVENTS-1:0])));

  assert_clr_reads_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == A_CLR) |=> (rdata_o == '0));

  assert_rd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

// File: rtl/evt_irq_bank.sv
module evt_irq_bank
  import eirq_pkg::*;
#(
  parameter int unsigned AW         = 12,
  parameter int unsigned NUM_CHAN   = 4,
  parameter int unsigned NUM_EVENTS = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  input  logic [NUM_CHAN-1:0]       evt_vld_i,
  input  logic [NUM_CHAN*IDX_W-1:0] evt_idx_i,
  output logic                      irq_o,
  output logic [NUM_EVENTS-1:0]     evt_irq_o
);
  localparam int unsigned DW = 32;

  logic [NUM_EVENTS-1:0] set_mask, clr_mask, raw, en, masked;

  eirq_evt_decode #(.NUM_CHAN(NUM_CHAN), .NUM_EVENTS(NUM_EVENTS)) u_dec (
    .evt_vld_i  (evt_vld_i),
    .evt_idx_i  (evt_idx_i),
    .set_mask_o (set_mask)
  );

  eirq_status #(.NUM_EVENTS(NUM_EVENTS)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_mask_i (set_mask),
    .clr_mask_i (clr_mask),
    .raw_o      (raw)
  );

  eirq_regs #(.AW(AW), .DW(DW), .NUM_EVENTS(NUM_EVENTS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .raw_i      (raw),
    .rdata_o    (rdata_o),
    .en_o       (en),
    .clr_mask_o (clr_mask)
  );

  assign masked    = raw & en;
  assign evt_irq_o = masked;
  assign irq_o     = |masked;

  assert_irq_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_o);
endmodule

// File: tb/tb_evt_irq_bank.sv
module tb_evt_irq_bank;
  localparam int NE = 16;
  localparam int NC = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NC-1:0]   vld = '0;
  logic [NC*5-1:0] idx = '0;
  logic            irq;
  logic [NE-1:0]   eirq;

  int checks = 0, fails = 0;

  evt_irq_bank #(.AW(12), .NUM_CHAN(NC), .NUM_EVENTS(NE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_vld_i(vld), .evt_idx_i(idx),
    .irq_o(irq), .evt_irq_o(eirq)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [NE-1:0] m_en, m_raw;
  logic [31:0]   m_rd;

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h020: return {16'h0, m_en};
      12'h024: return {16'h0, m_raw};
      12'h028: return {16'h0, m_raw & m_en};
      12'hE00: return 32'((NE - 1) * 131072);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = '0; m_raw = '0; m_rd = '0;
    end else begin
      logic [NE-1:0] s, c;
      s = '0;
      for (int k = 0; k < NC; k++) begin
        int ix;
        ix = int'(idx[k*5 +: 5]);
        if (vld[k] && ix < NE) s[ix] = 1'b1;
      end
      c = (req && we && addr == 12'h02C) ? wdata[NE-1:0] : '0;
      if (req && !we) m_rd = m_read(addr);
      m_raw = (m_raw & ~c) | s;
      if (req && we && addr == 12'h020) m_en = wdata[NE-1:0];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(irq == |(m_raw & m_en), "R7 irq_o model", 32'(irq), 32'(|(m_raw & m_en)));
      chk(eirq == (m_raw & m_en), "R7 evt_irq_o model", 32'(eirq), 32'(m_raw & m_en));
      chk(rdata == m_rd, "R11 rdata_o model", rdata, m_rd);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
    chk(rdata === exp, tag, rdata, exp);
  endtask

  task automatic ev(input int ch, input logic [4:0] ix);
    vld[ch] = 1'b1; idx[ch*5 +: 5] = ix;
    @(negedge clk);
    vld = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(irq === 1'b0, "R1 irq_o", 32'(irq), 0);
    chk(eirq === '0, "R1 evt_irq_o", 32'(eirq), 0);
    chk(rdata === '0, "R1 rdata_o", rdata, 0);
    rd(12'h020, 32'h0, "R1 enable reset");
    rd(12'h024, 32'h0, "R1 raw reset");
    // R9 config
    rd(12'hE00, 32'h001E_0000, "R9 config");
    wr(12'hE00, 32'hFFFF_FFFF);
    rd(12'hE00, 32'h001E_0000, "R9 config read-only");
    // R2 enable
    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h020, 32'h0000_FFFF, "R2 enable upper bits zero");
    wr(12'h020, 32'h0000_0005);
    rd(12'h020, 32'h0000_0005, "R2 enable readback");
    // R3 single and multi-channel events
    ev(0, 5'd2);
    chk(irq === 1'b1, "R7 irq after enabled event", 32'(irq), 1);
    chk(eirq === 16'h0004, "R7 evt_irq_o bit2", 32'(eirq), 32'h4);
    rd(12'h024, 32'h0000_0004, "R3 single event");
    vld = 4'b1111; idx = {5'd15, 5'd9, 5'd7, 5'd3};
    @(negedge clk); vld = '0;
    rd(12'h024, 32'h0000_828C, "R3 four channels same cycle");
    // R8 out-of-range
    vld = 4'b0110; idx = {5'd0, 5'd31, 5'd16, 5'd0};
    @(negedge clk); vld = '0;
    rd(12'h024, 32'h0000_828C, "R8 out-of-range ignored");
    // R4 sticky
    ev(3, 5'd2);
    rd(12'h024, 32'h0000_828C, "R4 repeat event");
    rd(12'h024, 32'h0000_828C, "R4 held without clear");
    // R7 masked
    rd(12'h028, 32'h0000_0004, "R7 masked status");
    // R5 clear
    wr(12'h02C, 32'h0000_0004);
    rd(12'h02C, 32'h0, "R5 clear reads zero");
    rd(12'h024, 32'h0000_8288, "R5 one bit cleared");
    rd(12'h028, 32'h0, "R7 masked after clear");
    chk(irq === 1'b0, "R7 irq low after clear", 32'(irq), 0);
    // R6 collision: bit3 event+clear, bit7 clear only
    req = 1; we = 1; addr = 12'h02C; wdata = 32'h0000_0088;
    vld[1] = 1'b1; idx[5 +: 5] = 5'd3;
    @(negedge clk);
    req = 0; we = 0; vld = '0;
    rd(12'h024, 32'h0000_8208, "R6 event wins over clear");
    // R10 unimplemented and read-only offsets
    rd(12'h030, 32'h0, "R10 unused offset reads zero");
    rd(12'h022, 32'h0, "R10 unaligned reads zero");
    wr(12'h030, 32'hFFFF_FFFF);
    wr(12'h024, 32'h0);
    wr(12'h028, 32'h0);
    rd(12'h024, 32'h0000_8208, "R10 raw unchanged by writes");
    rd(12'h020, 32'h0000_0005, "R10 enable unchanged");
    // R11 hold
    wr(12'h020, 32'h0000_8200);
    chk(rdata === 32'h5, "R11 rdata held over write", rdata, 32'h5);
    chk(eirq === 16'h8200, "R7 evt_irq_o new enable", 32'(eirq), 32'h8200);
    rd(12'h028, 32'h0000_8200, "R7 masked with new enable");
    // random traffic against model
    for (int n = 0; n < 4000; n++) begin
      int sel;
      sel = int'($urandom % 7);
      req = 1'($urandom);
      we = 1'($urandom);
      case (sel)
        0: addr = 12'h020; 1: addr = 12'h024; 2: addr = 12'h028;
        3: addr = 12'h02C; 4: addr = 12'hE00; 5: addr = 12'h030;
        default: addr = 12'h02C;
      endcase
      wdata = $urandom;
      vld = NC'($urandom & ($urandom | $urandom));
      idx = NC*5'($urandom);
      @(negedge clk);
    end
    req = 0; we = 0; vld = '0;
    wr(12'h02C, 32'hFFFF_FFFF);
    rd(12'h024, 32'h0, "R5 clear all");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule